// File: doc/BRIEF.md
# Eight-bit SPI engine with single-wire bidirectional mode

This block moves one byte at a time over a serial peripheral interface, either as the clock-driving master or as a slave clocked from outside. The data lines run in one of two layouts. In the normal layout one data pin carries data in and the other carries data out. In the single-wire layout one shared pin carries both directions, and a direction-enable input decides whether the block drives that pin. Which pin is shared depends on whether the block is master or slave. Every tri-state pin appears as three signals: input, output and output-enable.

As master, the block derives its serial clock from the bus clock through two stages. The first is a prescaler with eight choices. The second is a power-of-two divider. A wait-mode input can freeze all serial activity when stop-in-wait is selected. The transfer then resumes from the exact point where it stopped. When a received byte completes, a sticky full flag is set. A routing input sends that event either to an interrupt line or to a DMA request line, and never to both. Plain control inputs stand in for the configuration register bits.

Top module: `spi_bidir_engine`

## Requirements
- R1: With `one_wire`=0 the pin layout is normal. As master, `mosi_oe`=1, `miso_oe`=0, and data is received from `miso_i`. As slave, `miso_oe`=1, `mosi_oe`=0, and data is received from `mosi_i`.
- R2: With `one_wire`=1 as master, `miso_oe`=0 and `miso_i` is ignored. `mosi_oe` equals `dir_out`, and data is received from `mosi_i`.
- R3: With `one_wire`=1 as slave, `mosi_oe`=0 and `mosi_i` is ignored. `miso_oe` equals `dir_out`, and data is received from `miso_i`.
- R4: In single-wire mode with `dir_out`=0, the block drives no data pin. With `dir_out`=1, the shared pin carries transmit data and is sampled back as receive data, so the received byte equals the transmitted byte.
- R5: With `rx_dma_sel`=1, a full receive buffer raises `rx_dma_req` and keeps `rx_irq` at 0. With `rx_dma_sel`=0, it raises `rx_irq` and keeps `rx_dma_req` at 0.
- R6: With `stop_in_wait`=1 and `wait_mode`=1, the serial clock, the data output and the bit position are held. The transfer continues from that point once `wait_mode` falls. With `stop_in_wait`=0, wait mode has no effect on the transfer.
- R7: As master, the serial clock period is (P+1)·2^(min(D,8)+1) bus clocks, where P is `presc_sel` (0..7) and D is `rate_sel` (0..15).
- R8: Each transfer moves 8 bits, most significant first, in mode 0. The serial clock idles low. The outgoing bit is valid before each rising edge. Input is sampled on the rising edge, and the output changes on the falling edge.
- R9: After reset, `rx_full`=0, `tx_empty`=1 and `sck_out`=0. When a byte completes, `rx_data` holds it, `rx_full` becomes 1 and stays 1 until `rx_read` is pulsed, and `tx_empty` becomes 1. Pulsing `tx_load` clears `tx_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master, 0 = slave |
| one_wire | input | 1 | 1 = single-wire bidirectional pin layout |
| dir_out | input | 1 | Drive enable for the shared pin in single-wire mode |
| stop_in_wait | input | 1 | 1 = freeze serial activity while in wait mode |
| wait_mode | input | 1 | Wait-mode indication from the system |
| rx_dma_sel | input | 1 | 1 = receive-full goes to DMA, 0 = to interrupt |
| presc_sel | input | 3 | Prescaler select, divide by value+1 |
| rate_sel | input | 4 | Divider select, divide by 2^(min(value,8)+1) |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Pulse: load `tx_data`; as master, starts a transfer |
| rx_read | input | 1 | Pulse: acknowledge the received byte |
| sck_in | input | 1 | Serial clock input (slave) |
| sck_out | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI pin drive enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO pin drive enable |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| tx_empty | output | 1 | Transmit side free |
| rx_irq | output | 1 | Receive-full interrupt |
| rx_dma_req | output | 1 | Receive-full DMA request |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the engine with its default widths: an 8-bit byte, a 3-bit prescaler select and a 4-bit divider select clamped at 8. These are small enough to sweep every prescaler value against the four lowest divider settings, and also to reach the clamped divider settings, with the clock period checked arithmetically on each. All eight combinations of role, pin layout and direction bit are walked for pin ownership. Master and slave transfers are run in both layouts, with the unused pin fed contrary data. The wait-mode freeze is held for a long window partway through a byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int SPI_W = 8;
    localparam int CNT_W = $clog2(SPI_W);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             prev;
        logic             in_bit;
        logic [CNT_W-1:0] cnt;
        logic [SPI_W-1:0] sreg;
        logic [SPI_W-1:0] rx;
        logic             rx_full;
        logic             tx_empty;
    } core_st_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int PRE_W   = 3,
    parameter int DIV_W   = 4,
    parameter int DIV_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [PRE_W-1:0] presc_sel,
    input  logic [DIV_W-1:0] rate_sel,
    output logic             half_tick
);
    localparam int DC_W = (DIV_MAX > 0) ? DIV_MAX : 1;

    logic [PRE_W-1:0] pc_d, pc_q;
    logic [DC_W-1:0]  dc_d, dc_q, lim;
    logic [DIV_W-1:0] rate_eff;
    logic [DC_W:0]    pow;

    always_comb begin
        rate_eff  = (rate_sel > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : rate_sel;
        pow       = (DC_W+1)'(1) << rate_eff;
        lim       = DC_W'(pow - (DC_W+1)'(1));
        pc_d      = pc_q;
        dc_d      = dc_q;
        half_tick = 1'b0;
        if (!run) begin
            pc_d = '0;
            dc_d = '0;
        end else if (!hold) begin
            if (pc_q == presc_sel) begin
                pc_d = '0;
                if (dc_q == lim) begin
                    dc_d      = '0;
                    half_tick = 1'b1;
                end else begin
                    dc_d = dc_q + 1'b1;
                end
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            dc_q <= '0;
        end else begin
            pc_q <= pc_d;
            dc_q <= dc_d;
        end
    end

    // R7: the divider stage only advances on a prescaler wrap
    p_div_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pc_q != presc_sel) |=> (dc_q == $past(dc_q)));
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route (
    input  logic is_master,
    input  logic one_wire,
    input  logic dir_out,
    input  logic dout,
    input  logic mosi_i,
    input  logic miso_i,
    output logic mosi_o,
    output logic mosi_oe,
    output logic miso_o,
    output logic miso_oe,
    output logic din
);
    always_comb begin
        mosi_o = dout;
        miso_o = dout;
        if (!one_wire) begin
            mosi_oe = is_master;
            miso_oe = !is_master;
            din     = is_master ? miso_i : mosi_i;
        end else begin
            mosi_oe = is_master && dir_out;
            miso_oe = !is_master && dir_out;
            din     = is_master ? mosi_i : miso_i;
        end
    end

    always_comb begin
        if (one_wire && !dir_out)
            p_quiet_pins_r4: assert (!mosi_oe && !miso_oe);
        p_single_driver_r1: assert (!(mosi_oe && miso_oe));
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             freeze,
    input  logic             half_tick,
    input  logic             sck_in,
    input  logic             din,
    input  logic [SPI_W-1:0] tx_data,
    input  logic             tx_load,
    input  logic             rx_read,
    output logic             busy,
    output logic             sck_o,
    output logic             dout,
    output logic [SPI_W-1:0] rx_data,
    output logic             rx_full,
    output logic             tx_empty
);
    core_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sck_in;
        rise = is_master ? (half_tick && !st_q.sck) : (sck_in && !st_q.prev);
        fall = is_master ? (half_tick && st_q.sck)  : (!sck_in && st_q.prev);
        if (rx_read) st_d.rx_full = 1'b0;
        if (!freeze) begin
            if (tx_load && !st_q.busy) begin
                st_d.sreg     = tx_data;
                st_d.cnt      = '0;
                st_d.busy     = 1'b1;
                st_d.tx_empty = 1'b0;
                st_d.sck      = 1'b0;
            end else if (rise) begin
                st_d.in_bit = din;
                st_d.sck    = is_master;
            end else if (fall) begin
                st_d.sck  = 1'b0;
                st_d.sreg = {st_q.sreg[SPI_W-2:0], st_q.in_bit};
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(SPI_W-1)) begin
                    st_d.cnt      = '0;
                    st_d.rx       = {st_q.sreg[SPI_W-2:0], st_q.in_bit};
                    st_d.rx_full  = 1'b1;
                    st_d.tx_empty = 1'b1;
                    st_d.busy     = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.tx_empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign sck_o    = st_q.sck;
    assign dout     = st_q.sreg[SPI_W-1];
    assign rx_data  = st_q.rx;
    assign rx_full  = st_q.rx_full;
    assign tx_empty = st_q.tx_empty;

    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(st_q.cnt) && $stable(st_q.sreg) && $stable(st_q.sck)));
    p_rx_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rx_full && !rx_read) |=> st_q.rx_full);
    p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rx_full) |-> st_q.tx_empty);
    p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.sck);
endmodule

// File: rtl/spi_bidir_engine.sv
module spi_bidir_engine
    import spi_eng_pkg::*;
#(
    parameter int PRE_W   = 3,
    parameter int DIV_W   = 4,
    parameter int DIV_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             one_wire,
    input  logic             dir_out,
    input  logic             stop_in_wait,
    input  logic             wait_mode,
    input  logic             rx_dma_sel,
    input  logic [PRE_W-1:0] presc_sel,
    input  logic [DIV_W-1:0] rate_sel,
    input  logic [SPI_W-1:0] tx_data,
    input  logic             tx_load,
    input  logic             rx_read,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             mosi_i,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    output logic [SPI_W-1:0] rx_data,
    output logic             rx_full,
    output logic             tx_empty,
    output logic             rx_irq,
    output logic             rx_dma_req,
    output logic             busy
);
    logic freeze, half_tick, din, dout, sck_core;

    assign freeze = stop_in_wait && wait_mode;

    spi_baud_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy && is_master), .hold(freeze),
        .presc_sel(presc_sel), .rate_sel(rate_sel), .half_tick(half_tick)
    );

    spi_pin_route u_route (
        .is_master(is_master), .one_wire(one_wire), .dir_out(dir_out), .dout(dout),
        .mosi_i(mosi_i), .miso_i(miso_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_o(miso_o), .miso_oe(miso_oe), .din(din)
    );

    spi_shift_core u_core (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .freeze(freeze),
        .half_tick(half_tick), .sck_in(sck_in), .din(din), .tx_data(tx_data),
        .tx_load(tx_load), .rx_read(rx_read), .busy(busy), .sck_o(sck_core),
        .dout(dout), .rx_data(rx_data), .rx_full(rx_full), .tx_empty(tx_empty)
    );

    assign sck_out    = is_master && sck_core;
    assign sck_oe     = is_master;
    assign rx_irq     = rx_full && !rx_dma_sel;
    assign rx_dma_req = rx_full && rx_dma_sel;

    // R5: the routed event follows the full flag one-for-one
    p_route_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> (rx_irq || rx_dma_req));
endmodule

// File: tb/tb_spi_bidir_engine.sv
module tb_spi_bidir_engine;
    logic clk = 0, rst_n = 0;
    logic is_master = 1, one_wire = 0, dir_out = 0, stop_in_wait = 0, wait_mode = 0;
    logic rx_dma_sel = 0, tx_load = 0, rx_read = 0, sck_in = 0;
    logic [2:0] presc_sel = 0;
    logic [3:0] rate_sel = 0;
    logic [7:0] tx_data = 0, rx_data;
    logic sck_out, sck_oe, mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
    logic rx_full, tx_empty, rx_irq, rx_dma_req, busy;
    logic mosi_drv = 0, miso_drv = 0;
    int vectors = 0, errors = 0;

    always #10 clk = ~clk;

    assign mosi_i = mosi_oe ? mosi_o : mosi_drv;
    assign miso_i = miso_oe ? miso_o : miso_drv;

    spi_bidir_engine dut (.*);

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic drive_in(input bit b, input bit on_mosi);
        mosi_drv = on_mosi ? b : !b;
        miso_drv = on_mosi ? !b : b;
    endtask

    task automatic done_checks(input logic [7:0] exp_rx);
        chk(rx_data == exp_rx, "R9 rx_data", rx_data, exp_rx);
        chk(rx_full && tx_empty, "R9 flags", {rx_full, tx_empty}, 3);
        chk(rx_irq == !rx_dma_sel && rx_dma_req == rx_dma_sel, "R5 route",
            {rx_irq, rx_dma_req}, {!rx_dma_sel, rx_dma_sel});
        repeat (3) @(negedge clk);
        chk(rx_full, "R9 sticky", rx_full, 1);
        rx_read = 1; @(negedge clk); rx_read = 0;
        chk(!rx_full && !rx_irq && !rx_dma_req, "R9 read clears", rx_full, 0);
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] pat, input bit in_mosi,
                          input logic [7:0] exp_rx, input int exp_per, input bit chk_out,
                          input bit frz);
        logic [7:0] seen = 0;
        int k = 0, t = 0, t1 = 0, per = -1, guard = 0;
        logic ps = 0;
        @(negedge clk);
        tx_data = tx; tx_load = 1; drive_in(pat[7], in_mosi);
        @(negedge clk);
        tx_load = 0;
        chk(!tx_empty && busy, "R9 load clears tx_empty", tx_empty, 0);
        while (!rx_full && guard < 40000) begin
            if (sck_out && !ps) begin
                seen = {seen[6:0], mosi_o};
                k++;
                if (k == 1) t1 = t; else if (k == 2) per = t - t1;
                if (k < 8) drive_in(pat[7-k], in_mosi);
                if (frz && k == 4) begin
                    logic s0, d0, moved;
                    moved = 0; s0 = sck_out; d0 = mosi_o;
                    wait_mode = 1;
                    repeat (150) begin
                        @(negedge clk);
                        if (sck_out != s0 || mosi_o != d0 || rx_full) moved = 1;
                    end
                    chk(!moved, "R6 frozen in wait", moved, 0);
                    wait_mode = 0;
                    t = t + 150;
                end
            end
            ps = sck_out; t++; guard++;
            @(negedge clk);
        end
        chk(k == 8, "R8 eight edges", k, 8);
        if (exp_per > 0) chk(per == exp_per, "R7 period", per, exp_per);
        if (chk_out) chk(seen == tx, "R8 msb-first out", seen, tx);
        done_checks(exp_rx);
    endtask

    task automatic s_xfer(input logic [7:0] tx, input logic [7:0] pat, input bit in_mosi,
                          input logic [7:0] exp_rx, input bit chk_out);
        logic [7:0] seen = 0;
        @(negedge clk);
        tx_data = tx; tx_load = 1;
        @(negedge clk);
        tx_load = 0;
        for (int k = 0; k < 8; k++) begin
            drive_in(pat[7-k], in_mosi);
            repeat (2) @(negedge clk);
            seen = {seen[6:0], miso_o};
            sck_in = 1; repeat (3) @(negedge clk);
            sck_in = 0; repeat (3) @(negedge clk);
        end
        if (chk_out) chk(seen == tx, "R8 slave msb-first out", seen, tx);
        done_checks(exp_rx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!rx_full && tx_empty && !sck_out && !busy, "R9 reset",
            {rx_full, tx_empty, sck_out}, 2);

        // R1 R2 R3 R4: pin ownership over all role/layout/direction combos
        for (int c = 0; c < 8; c++) begin
            logic em, es;
            is_master = c[0]; one_wire = c[1]; dir_out = c[2];
            @(negedge clk);
            em = one_wire ? (is_master && dir_out) : is_master;
            es = one_wire ? (!is_master && dir_out) : !is_master;
            chk(mosi_oe == em && miso_oe == es, one_wire ? "R2 R3 one-wire oe" : "R1 normal oe",
                {mosi_oe, miso_oe}, {em, es});
        end

        // R7 R8 R1: master sweep over prescaler and low divider values
        is_master = 1; one_wire = 0; dir_out = 0;
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] tx, pat;
                tx = 8'hA5 ^ 8'(p * 37 + r * 11);
                pat = {tx[3:0], ~tx[7:4]};
                presc_sel = 3'(p); rate_sel = 4'(r); rx_dma_sel = r[0];
                m_xfer(tx, pat, 0, pat, (p + 1) * (1 << (r + 1)), 1, 0);
            end
        end
        // R7: divider clamp at 8
        presc_sel = 0;
        rate_sel = 8;  m_xfer(8'h3C, 8'hC9, 0, 8'hC9, 512, 1, 0);
        rate_sel = 15; m_xfer(8'h81, 8'h7E, 0, 8'h7E, 512, 1, 0);

        // R2 R4: single-wire master, loopback then receive with miso fed junk
        presc_sel = 1; rate_sel = 0;
        one_wire = 1; dir_out = 1; m_xfer(8'h6D, 8'h00, 0, 8'h6D, 4, 1, 0);
        dir_out = 0;               m_xfer(8'h11, 8'hB2, 1, 8'hB2, 4, 0, 0);

        // R6: stop-in-wait freeze mid-byte, then wait ignored when not selected
        one_wire = 0; stop_in_wait = 1; presc_sel = 2; rate_sel = 1;
        m_xfer(8'hE4, 8'h5B, 0, 8'h5B, 12, 1, 1);
        stop_in_wait = 0; wait_mode = 1;
        m_xfer(8'h27, 8'h9A, 0, 8'h9A, 12, 1, 0);
        wait_mode = 0;

        // R1 R3 R4: slave transfers
        is_master = 0; one_wire = 0; rx_dma_sel = 1;
        s_xfer(8'hC3, 8'h5E, 1, 8'h5E, 1);
        one_wire = 1; dir_out = 1; rx_dma_sel = 0;
        s_xfer(8'h96, 8'h00, 1, 8'h96, 1);
        dir_out = 0;
        s_xfer(8'h0F, 8'hD4, 0, 8'hD4, 0);
        chk(!miso_oe && !mosi_oe && !sck_oe, "R4 no drive in slave receive",
            {mosi_oe, miso_oe}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule